// File: doc/BRIEF.md
# Dual-Issue Pipe and Functional-Unit Reservation Arbiter

This block sits between decode and execute in a core with two asymmetric issue pipes. In each cycle it is offered up to two decoded instructions, slot 0 the older and slot 1 the younger, each with a 4-bit operation class. It decides which of them issue this cycle, and on which pipe or pipes each one goes. It also tracks the shared divider, the shared SIMD unit and any whole-machine hold. Classes that tie up a resource for several cycles load a down-counter when they issue. While that counter is non-zero, the resource is unavailable.

Grants are combinational from the offered slots and the counter state. A slot that is not granted is expected to be offered again, unchanged, in the next cycle. Issue is strictly in order: the younger slot never issues unless the older one does in the same cycle.

Top module: `dual_issue_arb`

## Requirements
- R1: Class codes route as follows. Code 2 (load or single store) may only use pipe 0. Codes 1 (multiply, count-leading-zeros, CRC), 3 (branch, call, trap), 4 (scalar FP), 7 to 11 (divider users) and 12 to 13 (SIMD) may only use pipe 1. Code 0 (simple ALU, shift, select, extended arithmetic) may use either pipe. Codes 5, 6, 14 and 15 take both pipes. Each pipe output has bit 0 for pipe 0 and bit 1 for pipe 1, and is 00 when its slot is not granted.
- R2: An either-pipe older instruction takes pipe 0, and an either-pipe younger one takes whichever pipe is left. The exception is a valid younger instruction of code 2: then the older either-pipe instruction takes pipe 1, so that both can issue.
- R3: The younger slot is granted only in a cycle where the older slot is also granted. A stalled older instruction blocks the younger one, even when the younger one's resources are free.
- R4: Two instructions never share a pipe. If both need the same single pipe, or both use the multiplier (code 1), the younger one stalls.
- R5: A both-pipe class issues alone. In slot 0 it gets pipe value 11 and slot 1 stalls. In slot 1 it stalls.
- R6: Once a divider class has issued, no divider class can issue for a further 21 cycles after code 7, 8 after code 8, 18 after code 9, 13 after code 10 and 27 after code 11. Classes that do not use the divider are unaffected.
- R7: Code 13 (wide SIMD and AES round/mix) keeps the SIMD unit busy for one cycle after issue. Code 12 frees it at once. A SIMD class offered while the unit is busy stalls.
- R8: After issue, nothing at all issues for a further 1 cycle after code 6, 159 cycles after code 14 and 319 cycles after code 15. Code 5 holds nothing beyond its issue cycle.
- R9: Reset clears every busy counter, so an instruction offered right after reset issues at once.
- R10: A slot is granted only when its valid input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot0_valid_i | input | 1 | Older slot carries an instruction |
| slot0_class_i | input | 4 | Older slot operation class |
| slot1_valid_i | input | 1 | Younger slot carries an instruction |
| slot1_class_i | input | 4 | Younger slot operation class |
| slot0_grant_o | output | 1 | Older slot issues this cycle |
| slot1_grant_o | output | 1 | Younger slot issues this cycle |
| slot0_pipe_o | output | 2 | Pipes taken by the older slot |
| slot1_pipe_o | output | 2 | Pipes taken by the younger slot |

## Verification
Some properties are checked by assertions on every cycle:
- in-order granting, granting only when valid, and pipe exclusivity;
- per-class routing, including the pipe-1 placement of an older either-pipe instruction;
- the one-cycle consequences of issuing a divider, wide-SIMD or machine-hold class.

The full length of each hold window can only be shown by the bench scenarios. They repeat a blocked class every cycle and count the stall cycles against the figure stated for each class. Clearing of long holds by reset is checked the same way.

// File: rtl/issue_arb_pkg.sv
package issue_arb_pkg;

  localparam int CLS_W   = 4;
  localparam int NUM_CTR = 3;
  localparam int CTR_DIV  = 0;
  localparam int CTR_SIMD = 1;
  localparam int CTR_PIPE = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU    = 4'd0,
    CLS_MUL    = 4'd1,
    CLS_MEM    = 4'd2,
    CLS_BRANCH = 4'd3,
    CLS_FP     = 4'd4,
    CLS_PAIR   = 4'd5,
    CLS_STPQ   = 4'd6,
    CLS_DIV32  = 4'd7,
    CLS_FDIVS  = 4'd8,
    CLS_FDIVD  = 4'd9,
    CLS_FSQRTS = 4'd10,
    CLS_FSQRTD = 4'd11,
    CLS_SIMD   = 4'd12,
    CLS_SIMDQ  = 4'd13,
    CLS_TBL64  = 4'd14,
    CLS_TBL128 = 4'd15
  } op_class_e;

  typedef enum logic [1:0] {
    NEED_ANY  = 2'd0,
    NEED_P0   = 2'd1,
    NEED_P1   = 2'd2,
    NEED_BOTH = 2'd3
  } pipe_need_e;

  typedef enum logic [1:0] {
    UNIT_NONE = 2'd0,
    UNIT_MUL  = 2'd1,
    UNIT_DIV  = 2'd2,
    UNIT_SIMD = 2'd3
  } unit_e;

  localparam logic [1:0] PIPE_NONE = 2'b00;
  localparam logic [1:0] PIPE_0    = 2'b01;
  localparam logic [1:0] PIPE_1    = 2'b10;
  localparam logic [1:0] PIPE_BOTH = 2'b11;

endpackage

// File: rtl/issue_class_dec.sv
module issue_class_dec
  import issue_arb_pkg::*;
#(
  parameter int HOLD_W      = 9,
  parameter int DIV32_HOLD  = 21,
  parameter int FDIVS_HOLD  = 8,
  parameter int FDIVD_HOLD  = 18,
  parameter int FSQRTS_HOLD = 13,
  parameter int FSQRTD_HOLD = 27,
  parameter int SIMDQ_HOLD  = 1,
  parameter int STPQ_HOLD   = 1,
  parameter int TBL64_HOLD  = 159,
  parameter int TBL128_HOLD = 319
) (
  input  logic [CLS_W-1:0]  cls_i,
  output pipe_need_e        need_o,
  output unit_e             unit_o,
  output logic [HOLD_W-1:0] hold_o
);

  op_class_e cls;
  assign cls = op_class_e'(cls_i);

  always_comb begin
    need_o = NEED_P1;
    unit_o = UNIT_NONE;
    hold_o = '0;
    unique case (cls)
      CLS_ALU:    need_o = NEED_ANY;
      CLS_MEM:    need_o = NEED_P0;
      CLS_MUL:    unit_o = UNIT_MUL;
      CLS_BRANCH,
      CLS_FP:     need_o = NEED_P1;
      CLS_PAIR:   need_o = NEED_BOTH;
      CLS_STPQ: begin
        need_o = NEED_BOTH;
        hold_o = HOLD_W'(STPQ_HOLD);
      end
      CLS_TBL64: begin
        need_o = NEED_BOTH;
        hold_o = HOLD_W'(TBL64_HOLD);
      end
      CLS_TBL128: begin
        need_o = NEED_BOTH;
        hold_o = HOLD_W'(TBL128_HOLD);
      end
      CLS_DIV32: begin
        unit_o = UNIT_DIV;
        hold_o = HOLD_W'(DIV32_HOLD);
      end
      CLS_FDIVS: begin
        unit_o = UNIT_DIV;
        hold_o = HOLD_W'(FDIVS_HOLD);
      end
      CLS_FDIVD: begin
        unit_o = UNIT_DIV;
        hold_o = HOLD_W'(FDIVD_HOLD);
      end
      CLS_FSQRTS: begin
        unit_o = UNIT_DIV;
        hold_o = HOLD_W'(FSQRTS_HOLD);
      end
      CLS_FSQRTD: begin
        unit_o = UNIT_DIV;
        hold_o = HOLD_W'(FSQRTD_HOLD);
      end
      CLS_SIMD:   unit_o = UNIT_SIMD;
      CLS_SIMDQ: begin
        unit_o = UNIT_SIMD;
        hold_o = HOLD_W'(SIMDQ_HOLD);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/unit_busy_ctr.sv
module unit_busy_ctr #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         busy_o
);

  logic [W-1:0] cnt_q;

  // counts cycles still reserved after the issue cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/issue_pair_sel.sv
module issue_pair_sel
  import issue_arb_pkg::*;
(
  input  logic       valid0_i,
  input  pipe_need_e need0_i,
  input  unit_e      unit0_i,
  input  logic       valid1_i,
  input  pipe_need_e need1_i,
  input  unit_e      unit1_i,
  input  logic       div_busy_i,
  input  logic       simd_busy_i,
  input  logic       pipe_hold_i,
  output logic       grant0_o,
  output logic       grant1_o,
  output logic [1:0] pipe0_o,
  output logic [1:0] pipe1_o
);

  function automatic logic unit_free(unit_e u, logic div_b, logic simd_b);
    return !((u == UNIT_DIV) && div_b) && !((u == UNIT_SIMD) && simd_b);
  endfunction

  logic       ok0, ok1;
  logic [1:0] want0, free_pipes, want1;
  logic       unit_clash;

  assign ok0 = valid0_i && !pipe_hold_i && unit_free(unit0_i, div_busy_i, simd_busy_i);

  always_comb begin
    unique case (need0_i)
      // older either-pipe op yields pipe 0 to a pipe-0-only younger op
      NEED_ANY:  want0 = (valid1_i && need1_i == NEED_P0) ? PIPE_1 : PIPE_0;
      NEED_P0:   want0 = PIPE_0;
      NEED_P1:   want0 = PIPE_1;
      default:   want0 = PIPE_BOTH;
    endcase
  end

  assign pipe0_o    = ok0 ? want0 : PIPE_NONE;
  assign free_pipes = ~pipe0_o;

  always_comb begin
    unique case (need1_i)
      NEED_ANY:  want1 = free_pipes[0] ? PIPE_0 : (free_pipes[1] ? PIPE_1 : PIPE_NONE);
      NEED_P0:   want1 = free_pipes[0] ? PIPE_0 : PIPE_NONE;
      NEED_P1:   want1 = free_pipes[1] ? PIPE_1 : PIPE_NONE;
      default:   want1 = PIPE_NONE;
    endcase
  end

  assign unit_clash = (unit1_i != UNIT_NONE) && (unit1_i == unit0_i);

  assign ok1 = ok0 && valid1_i && (want1 != PIPE_NONE) && !unit_clash &&
               unit_free(unit1_i, div_busy_i, simd_busy_i);

  assign grant0_o = ok0;
  assign grant1_o = ok1;
  assign pipe1_o  = ok1 ? want1 : PIPE_NONE;

endmodule

// File: rtl/dual_issue_arb.sv
module dual_issue_arb
  import issue_arb_pkg::*;
#(
  parameter int DIV32_HOLD  = 21,
  parameter int FDIVS_HOLD  = 8,
  parameter int FDIVD_HOLD  = 18,
  parameter int FSQRTS_HOLD = 13,
  parameter int FSQRTD_HOLD = 27,
  parameter int SIMDQ_HOLD  = 1,
  parameter int STPQ_HOLD   = 1,
  parameter int TBL64_HOLD  = 159,
  parameter int TBL128_HOLD = 319
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot0_valid_i,
  input  logic [CLS_W-1:0] slot0_class_i,
  input  logic             slot1_valid_i,
  input  logic [CLS_W-1:0] slot1_class_i,
  output logic             slot0_grant_o,
  output logic             slot1_grant_o,
  output logic [1:0]       slot0_pipe_o,
  output logic [1:0]       slot1_pipe_o
);

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_HOLD = imax(imax(imax(DIV32_HOLD, FDIVS_HOLD), imax(FDIVD_HOLD, FSQRTS_HOLD)),
                                 imax(imax(FSQRTD_HOLD, SIMDQ_HOLD),
                                      imax(STPQ_HOLD, imax(TBL64_HOLD, TBL128_HOLD))));
  localparam int HOLD_W   = $clog2(MAX_HOLD + 1);
  localparam int NSLOT    = 2;

  logic [CLS_W-1:0]  cls   [NSLOT];
  logic              valid [NSLOT];
  logic              grant [NSLOT];
  pipe_need_e        need  [NSLOT];
  unit_e             unit  [NSLOT];
  logic [HOLD_W-1:0] hold  [NSLOT];
  logic              busy  [NUM_CTR];

  assign cls[0]   = slot0_class_i;
  assign cls[1]   = slot1_class_i;
  assign valid[0] = slot0_valid_i;
  assign valid[1] = slot1_valid_i;

  for (genvar s = 0; s < NSLOT; s++) begin : g_dec
    issue_class_dec #(
      .HOLD_W      (HOLD_W),
      .DIV32_HOLD  (DIV32_HOLD),
      .FDIVS_HOLD  (FDIVS_HOLD),
      .FDIVD_HOLD  (FDIVD_HOLD),
      .FSQRTS_HOLD (FSQRTS_HOLD),
      .FSQRTD_HOLD (FSQRTD_HOLD),
      .SIMDQ_HOLD  (SIMDQ_HOLD),
      .STPQ_HOLD   (STPQ_HOLD),
      .TBL64_HOLD  (TBL64_HOLD),
      .TBL128_HOLD (TBL128_HOLD)
    ) u_dec (
      .cls_i  (cls[s]),
      .need_o (need[s]),
      .unit_o (unit[s]),
      .hold_o (hold[s])
    );
  end

  issue_pair_sel u_sel (
    .valid0_i    (valid[0]),
    .need0_i     (need[0]),
    .unit0_i     (unit[0]),
    .valid1_i    (valid[1]),
    .need1_i     (need[1]),
    .unit1_i     (unit[1]),
    .div_busy_i  (busy[CTR_DIV]),
    .simd_busy_i (busy[CTR_SIMD]),
    .pipe_hold_i (busy[CTR_PIPE]),
    .grant0_o    (grant[0]),
    .grant1_o    (grant[1]),
    .pipe0_o     (slot0_pipe_o),
    .pipe1_o     (slot1_pipe_o)
  );

  assign slot0_grant_o = grant[0];
  assign slot1_grant_o = grant[1];

  function automatic logic uses_ctr(int k, pipe_need_e n, unit_e u);
    if (k == CTR_DIV)  return u == UNIT_DIV;
    if (k == CTR_SIMD) return u == UNIT_SIMD;
    return n == NEED_BOTH;
  endfunction

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic              hit0, hit1;
    logic [HOLD_W-1:0] ld_val;

    assign hit0   = grant[0] && uses_ctr(k, need[0], unit[0]);
    assign hit1   = grant[1] && uses_ctr(k, need[1], unit[1]);
    assign ld_val = hit0 ? hold[0] : hold[1];

    unit_busy_ctr #(.W(HOLD_W)) u_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (hit0 || hit1),
      .load_val_i (ld_val),
      .busy_o     (busy[k])
    );
  end

endmodule

// File: rtl/dual_issue_arb_chk.sv
module dual_issue_arb_chk
  import issue_arb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slot0_valid_i,
  input logic [CLS_W-1:0] slot0_class_i,
  input logic             slot1_valid_i,
  input logic [CLS_W-1:0] slot1_class_i,
  input logic             slot0_grant_o,
  input logic             slot1_grant_o,
  input logic [1:0]       slot0_pipe_o,
  input logic [1:0]       slot1_pipe_o
);

  logic p1only0, p1only1, div0, div1, simd0, simd1, both0;

  assign p1only0 = slot0_class_i inside {4'd1, 4'd3, 4'd4, [4'd7:4'd13]};
  assign p1only1 = slot1_class_i inside {4'd1, 4'd3, 4'd4, [4'd7:4'd13]};
  assign div0    = slot0_class_i inside {[4'd7:4'd11]};
  assign div1    = slot1_class_i inside {[4'd7:4'd11]};
  assign simd0   = slot0_class_i inside {4'd12, 4'd13};
  assign simd1   = slot1_class_i inside {4'd12, 4'd13};
  assign both0   = slot0_class_i inside {4'd5, 4'd6, 4'd14, 4'd15};

  // R3
  in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot1_grant_o |-> slot0_grant_o);

  // R10
  grant0_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot0_grant_o |-> slot0_valid_i);

  // R10
  grant1_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot1_grant_o |-> slot1_valid_i);

  // R4
  pipe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot0_pipe_o & slot1_pipe_o) == 2'b00);

  // R1
  nogrant_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot0_grant_o |-> slot0_pipe_o == 2'b00);

  // R1
  mem_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot1_grant_o && slot1_class_i == 4'd2) |-> slot1_pipe_o == 2'b01);

  // R1
  p1_route0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot0_grant_o && p1only0) |-> slot0_pipe_o == 2'b10);

  // R1
  p1_route1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot1_grant_o && p1only1) |-> slot1_pipe_o == 2'b10);

  // R2
  older_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot0_grant_o && slot0_class_i == 4'd0 && slot1_valid_i && slot1_class_i == 4'd2)
      |-> slot0_pipe_o == 2'b10);

  // R5
  both_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot0_grant_o && both0) |-> (slot0_pipe_o == 2'b11 && !slot1_grant_o));

  // R6
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slot0_grant_o && div0) || (slot1_grant_o && div1))
      |=> !((slot0_grant_o && div0) || (slot1_grant_o && div1)));

  // R7
  simdq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slot0_grant_o && slot0_class_i == 4'd13) || (slot1_grant_o && slot1_class_i == 4'd13))
      |=> !((slot0_grant_o && simd0) || (slot1_grant_o && simd1)));

  // R8
  pipe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot0_grant_o && slot0_class_i inside {4'd6, 4'd14, 4'd15}) |=> !slot0_grant_o);

endmodule

bind dual_issue_arb dual_issue_arb_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .slot0_valid_i (slot0_valid_i),
  .slot0_class_i (slot0_class_i),
  .slot1_valid_i (slot1_valid_i),
  .slot1_class_i (slot1_class_i),
  .slot0_grant_o (slot0_grant_o),
  .slot1_grant_o (slot1_grant_o),
  .slot0_pipe_o  (slot0_pipe_o),
  .slot1_pipe_o  (slot1_pipe_o)
);

// File: tb/dual_issue_arb_test.sv
module dual_issue_arb_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 16;

  typedef struct packed {
    logic       v0;
    logic [3:0] c0;
    logic       v1;
    logic [3:0] c1;
    logic       g0;
    logic       g1;
    logic [1:0] p0;
    logic [1:0] p1;
  } vec_t;

  // v0 c0 v1 c1 | g0 g1 p0 p1
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'd0,  1'b1, 4'd0,  1'b1, 1'b1, 2'b01, 2'b10}, // R2 alu alu
    '{1'b1, 4'd2,  1'b1, 4'd0,  1'b1, 1'b1, 2'b01, 2'b10}, // R1 mem alu
    '{1'b1, 4'd0,  1'b1, 4'd2,  1'b1, 1'b1, 2'b10, 2'b01}, // R2 alu mem swap
    '{1'b1, 4'd1,  1'b1, 4'd0,  1'b1, 1'b1, 2'b10, 2'b01}, // R1 mul alu
    '{1'b1, 4'd1,  1'b1, 4'd1,  1'b1, 1'b0, 2'b10, 2'b00}, // R4 mul mul
    '{1'b1, 4'd1,  1'b1, 4'd3,  1'b1, 1'b0, 2'b10, 2'b00}, // R4 mul branch
    '{1'b1, 4'd3,  1'b1, 4'd2,  1'b1, 1'b1, 2'b10, 2'b01}, // R1 branch mem
    '{1'b1, 4'd2,  1'b1, 4'd2,  1'b1, 1'b0, 2'b01, 2'b00}, // R4 mem mem
    '{1'b1, 4'd5,  1'b1, 4'd0,  1'b1, 1'b0, 2'b11, 2'b00}, // R5 pair alu
    '{1'b1, 4'd0,  1'b1, 4'd5,  1'b1, 1'b0, 2'b01, 2'b00}, // R5 alu pair
    '{1'b1, 4'd12, 1'b1, 4'd2,  1'b1, 1'b1, 2'b10, 2'b01}, // R1 simd mem
    '{1'b0, 4'd0,  1'b1, 4'd0,  1'b0, 1'b0, 2'b00, 2'b00}, // R10 older invalid
    '{1'b1, 4'd4,  1'b1, 4'd2,  1'b1, 1'b1, 2'b10, 2'b01}, // R1 fp mem
    '{1'b1, 4'd13, 1'b1, 4'd2,  1'b1, 1'b1, 2'b10, 2'b01}, // R7 simdq mem
    '{1'b1, 4'd12, 1'b1, 4'd2,  1'b0, 1'b0, 2'b00, 2'b00}, // R3 simd busy blocks mem
    '{1'b1, 4'd12, 1'b1, 4'd2,  1'b1, 1'b1, 2'b10, 2'b01}  // R7 simd free again
  };

  logic       clk;
  logic       rst_n;
  logic       v0, v1;
  logic [3:0] c0, c1;
  logic       g0, g1;
  logic [1:0] p0, p1;

  int errors = 0;
  int checks = 0;

  dual_issue_arb uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .slot0_valid_i (v0),
    .slot0_class_i (c0),
    .slot1_valid_i (v1),
    .slot1_class_i (c1),
    .slot0_grant_o (g0),
    .slot1_grant_o (g1),
    .slot0_pipe_o  (p0),
    .slot1_pipe_o  (p1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic [3:0] ca, input logic b, input logic [3:0] cb);
    v0 = a; c0 = ca; v1 = b; c1 = cb;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    drive(1'b0, 4'd0, 1'b0, 4'd0);
    repeat (n) step();
  endtask

  task automatic expect_out(input string req, input string what, input logic eg0, input logic eg1,
                            input logic [1:0] ep0, input logic [1:0] ep1);
    @(negedge clk);
    check({g0, g1, p0, p1} == {eg0, eg1, ep0, ep1}, req, what,
          int'({g0, g1, p0, p1}), int'({eg0, eg1, ep0, ep1}));
  endtask

  task automatic hold_test(input logic [3:0] first, input logic [1:0] pexp,
                           input logic [3:0] probe, input int n, input string req);
    int cnt;
    drive(1'b1, first, 1'b0, 4'd0);
    expect_out(req, "first issue", 1'b1, 1'b0, pexp, 2'b00);
    step();
    drive(1'b1, probe, 1'b0, 4'd0);
    cnt = 0;
    forever begin
      @(negedge clk);
      if (g0 || cnt > n + 5) break;
      cnt++;
      step();
    end
    check(cnt == n, req, "stall cycles", cnt, n);
    step();
    idle(40);
  endtask

  task automatic run_all();
    drive(1'b0, 4'd0, 1'b0, 4'd0);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R9 reset state: both slots issue at once
    drive(1'b1, 4'd0, 1'b1, 4'd0);
    expect_out("R9", "after reset", 1'b1, 1'b1, 2'b01, 2'b10);
    step();

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].v0, VECS[i].c0, VECS[i].v1, VECS[i].c1);
      @(negedge clk);
      check({g0, g1, p0, p1} == {VECS[i].g0, VECS[i].g1, VECS[i].p0, VECS[i].p1},
            $sformatf("R1-table vec%0d", i), "grant/pipe",
            int'({g0, g1, p0, p1}), int'({VECS[i].g0, VECS[i].g1, VECS[i].p0, VECS[i].p1}));
      step();
    end
    idle(4);

    // R6 busy divider blocks younger divide only; R3 older still goes
    drive(1'b1, 4'd7, 1'b0, 4'd0);
    expect_out("R6", "div issue", 1'b1, 1'b0, 2'b10, 2'b00);
    step();
    drive(1'b1, 4'd0, 1'b1, 4'd7);
    expect_out("R6", "alu with blocked div", 1'b1, 1'b0, 2'b01, 2'b00);
    step();
    drive(1'b1, 4'd0, 1'b1, 4'd2);
    expect_out("R6", "non-div ops during div", 1'b1, 1'b1, 2'b10, 2'b01);
    step();
    idle(30);

    hold_test(4'd7,  2'b10, 4'd7,  21, "R6");
    hold_test(4'd8,  2'b10, 4'd10, 8,  "R6");
    hold_test(4'd9,  2'b10, 4'd7,  18, "R6");
    hold_test(4'd10, 2'b10, 4'd8,  13, "R6");
    hold_test(4'd11, 2'b10, 4'd8,  27, "R6");
    hold_test(4'd13, 2'b10, 4'd12, 1,  "R7");
    hold_test(4'd12, 2'b10, 4'd12, 0,  "R7");
    hold_test(4'd6,  2'b11, 4'd0,  1,  "R8");
    hold_test(4'd5,  2'b11, 4'd0,  0,  "R8");
    hold_test(4'd14, 2'b11, 4'd0,  159, "R8");
    hold_test(4'd15, 2'b11, 4'd0,  319, "R8");

    // R9 reset in the middle of a long hold
    drive(1'b1, 4'd15, 1'b0, 4'd0);
    expect_out("R9", "tbl128 issue", 1'b1, 1'b0, 2'b11, 2'b00);
    step();
    drive(1'b0, 4'd0, 1'b0, 4'd0);
    repeat (5) step();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    drive(1'b1, 4'd0, 1'b1, 4'd0);
    expect_out("R9", "issue right after reset", 1'b1, 1'b1, 2'b01, 2'b10);
    step();
    idle(2);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog R1..R10: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule